// File: doc/BRIEF.md
# Signed Energy Accumulator with Split Readout

This block sums a signed per-sample power value into a 45-bit two's-complement energy register. The register is shown to the host as two words: a 32-bit high word, which is the register arithmetically shifted right by 13, and a 13-bit low word, which holds the remaining bits. A sample strobe marks each valid power sample. A separate strobe marks each half line cycle.

The block has two user models. In the free-running model, every enabled sample is added to the register. The host usually reads only the high word, and a read of that word can zero it. In the interval model, a hidden running sum collects samples. Once per interval it copies that sum into the visible register and raises a one-clock ready pulse. The interval length is counted in samples or in half line cycles, and spans the programmed count plus one units.

A sticky flag records any signed overflow of either sum. Additions wrap at 45 bits.

Top module: `egy_split_accum`

## Requirements
- R1: After reset, hi_word and lo_word are zero, and rdy and ovf are low.
- R2: With cfg_en=1 and cfg_load=0, every clock with smp_stb=1 adds the sign-extended pwr_smp to the 45-bit register. In the following cycle, hi_word shows bits 44..13 of the register (the value shifted right by 13 with sign) and lo_word shows bits 12..0.
- R3: With cfg_en=0, samples and strobes change neither word and no rdy pulse occurs.
- R4: A clock with rd_stb=1, rd_sel=1 (high word) and cfg_rdclr=1 sets hi_word to zero and leaves lo_word unchanged. With rd_sel=0 or cfg_rdclr=0, a read has no effect on either word.
- R5: If a high-word clear and a free-running addition fall on the same clock, the result is {zero high part, old low part} plus the sample, so no sample is lost.
- R6: With cfg_en=1, cfg_load=1 and cfg_tmr=0, a ready event occurs on the (cfg_intvl+1)-th sample strobe after the previous ready event (or after entering the mode). The register then takes the hidden sum of the samples seen strictly between the two ready clocks, plus the sample at the previous ready clock. The sample at the ready clock opens the new interval, and no low-order residue carries over.
- R7: With cfg_tmr=1, the interval is counted on hcyc_stb instead. A ready event occurs on the (cfg_intvl+1)-th half-cycle strobe, and a sample arriving on that same clock belongs to the new interval.
- R8: rdy is high for exactly the clock after each ready event, and the new total is visible on the words in that same cycle. In the interval model the words change only at ready events or by a read-clear.
- R9: If a ready event and a high-word clear fall on the same clock, the ready event takes precedence: the words show the delivered total.
- R10: Sums wrap in two's complement at 45 bits. ovf goes high after the first addition whose true result falls outside [-2^44, 2^44-1], and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | Power sample valid |
| hcyc_stb | input | 1 | Half line cycle marker |
| pwr_smp | input | 32 | Signed power sample |
| cfg_en | input | 1 | Accumulation enable |
| cfg_load | input | 1 | 1 = interval model, 0 = free-running |
| cfg_tmr | input | 1 | Interval unit: 1 = half cycles, 0 = samples |
| cfg_rdclr | input | 1 | Enable zeroing of high word on read |
| cfg_intvl | input | 16 | Interval length minus one |
| rd_stb | input | 1 | Host read strobe |
| rd_sel | input | 1 | Word select: 1 = high, 0 = low |
| hi_word | output | 32 | Register bits 44..13 |
| lo_word | output | 13 | Register bits 12..0 |
| rdy | output | 1 | One-clock interval-ready pulse |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The bench uses the default widths: a 45-bit register, a 13-bit low word, 32-bit samples and a 16-bit interval count. Intervals are programmed short at run time (counts of 0, 1 and 3), so many ready events in both timer modes fit into a few dozen cycles. Because a full-scale 32-bit sample is only 2^13 times smaller than the register's range, 8193 back-to-back full-scale samples are enough to reach a real 45-bit overflow and its wrap.

// File: rtl/egy_pkg.sv
package egy_pkg;
  localparam int unsigned DEF_ACC_W = 45;
  localparam int unsigned DEF_LO_W  = 13;
  localparam int unsigned DEF_PWR_W = 32;
  localparam int unsigned DEF_CNT_W = 16;

  typedef enum logic {
    WSEL_LO = 1'b0,
    WSEL_HI = 1'b1
  } word_sel_e;
endpackage

// File: rtl/egy_interval_timer.sv
module egy_interval_timer #(
  parameter int unsigned CNT_W = egy_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             unit_stb,
  input  logic [CNT_W-1:0] intvl,
  output logic             evt
);
  logic [CNT_W-1:0] cnt_q;

  assign evt = run && unit_stb && (cnt_q >= intvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
    end else if (unit_stb) begin
      cnt_q <= evt ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/egy_interval_sum.sv
module egy_interval_sum #(
  parameter int unsigned ACC_W = egy_pkg::DEF_ACC_W,
  parameter int unsigned PWR_W = egy_pkg::DEF_PWR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             smp_stb,
  input  logic [PWR_W-1:0] pwr_smp,
  input  logic             evt,
  output logic [ACC_W-1:0] sum_q,
  output logic             ovf_evt
);
  localparam int unsigned EXT_W = ACC_W - PWR_W;

  function automatic logic [ACC_W-1:0] sext(input logic [PWR_W-1:0] p);
    return {{EXT_W{p[PWR_W-1]}}, p};
  endfunction

  function automatic logic add_ovf(input logic [ACC_W-1:0] a,
                                   input logic [ACC_W-1:0] b);
    logic [ACC_W-1:0] s;
    s = a + b;
    return (a[ACC_W-1] == b[ACC_W-1]) && (s[ACC_W-1] != a[ACC_W-1]);
  endfunction

  logic [ACC_W-1:0] smp_ext;
  assign smp_ext = sext(pwr_smp);
  assign ovf_evt = run && smp_stb && !evt && add_ovf(sum_q, smp_ext);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
    end else if (!run) begin
      sum_q <= '0;
    end else if (evt) begin
      sum_q <= smp_stb ? smp_ext : '0;
    end else if (smp_stb) begin
      sum_q <= sum_q + smp_ext;
    end
  end
endmodule

// File: rtl/egy_user_reg.sv
module egy_user_reg #(
  parameter int unsigned ACC_W = egy_pkg::DEF_ACC_W,
  parameter int unsigned LO_W  = egy_pkg::DEF_LO_W,
  parameter int unsigned PWR_W = egy_pkg::DEF_PWR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_hi,
  input  logic             acc_add,
  input  logic [PWR_W-1:0] pwr_smp,
  input  logic             load_evt,
  input  logic [ACC_W-1:0] load_val,
  output logic [ACC_W-1:0] user_q,
  output logic             ovf_evt
);
  localparam int unsigned HI_W  = ACC_W - LO_W;
  localparam int unsigned EXT_W = ACC_W - PWR_W;

  function automatic logic [ACC_W-1:0] sext(input logic [PWR_W-1:0] p);
    return {{EXT_W{p[PWR_W-1]}}, p};
  endfunction

  function automatic logic add_ovf(input logic [ACC_W-1:0] a,
                                   input logic [ACC_W-1:0] b);
    logic [ACC_W-1:0] s;
    s = a + b;
    return (a[ACC_W-1] == b[ACC_W-1]) && (s[ACC_W-1] != a[ACC_W-1]);
  endfunction

  logic [ACC_W-1:0] base;
  logic [ACC_W-1:0] smp_ext;

  assign base    = clr_hi ? {{HI_W{1'b0}}, user_q[LO_W-1:0]} : user_q;
  assign smp_ext = sext(pwr_smp);
  assign ovf_evt = !load_evt && acc_add && add_ovf(base, smp_ext);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      user_q <= '0;
    end else if (load_evt) begin
      user_q <= load_val;
    end else if (acc_add) begin
      user_q <= base + smp_ext;
    end else if (clr_hi) begin
      user_q <= base;
    end
  end
endmodule

// File: rtl/egy_split_accum.sv
module egy_split_accum #(
  parameter int unsigned ACC_W = egy_pkg::DEF_ACC_W,
  parameter int unsigned LO_W  = egy_pkg::DEF_LO_W,
  parameter int unsigned PWR_W = egy_pkg::DEF_PWR_W,
  parameter int unsigned CNT_W = egy_pkg::DEF_CNT_W,
  localparam int unsigned HI_W = ACC_W - LO_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_stb,
  input  logic             hcyc_stb,
  input  logic [PWR_W-1:0] pwr_smp,
  input  logic             cfg_en,
  input  logic             cfg_load,
  input  logic             cfg_tmr,
  input  logic             cfg_rdclr,
  input  logic [CNT_W-1:0] cfg_intvl,
  input  logic             rd_stb,
  input  logic             rd_sel,
  output logic [HI_W-1:0]  hi_word,
  output logic [LO_W-1:0]  lo_word,
  output logic             rdy,
  output logic             ovf
);
  // named internal events, observed by the bound checker
  logic             run;
  logic             unit_stb;
  logic             load_evt;
  logic             clr_hi;
  logic             acc_add;
  logic             sum_ovf;
  logic             usr_ovf;
  logic [ACC_W-1:0] isum;
  logic [ACC_W-1:0] user_q;
  logic             rdy_q;
  logic             ovf_q;

  assign run      = cfg_en && cfg_load;
  assign unit_stb = cfg_tmr ? hcyc_stb : smp_stb;
  assign clr_hi   = rd_stb && (rd_sel == egy_pkg::WSEL_HI) && cfg_rdclr;
  assign acc_add  = cfg_en && !cfg_load && smp_stb;

  egy_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .unit_stb (unit_stb),
    .intvl    (cfg_intvl),
    .evt      (load_evt)
  );

  egy_interval_sum #(.ACC_W(ACC_W), .PWR_W(PWR_W)) u_isum (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .smp_stb (smp_stb),
    .pwr_smp (pwr_smp),
    .evt     (load_evt),
    .sum_q   (isum),
    .ovf_evt (sum_ovf)
  );

  egy_user_reg #(.ACC_W(ACC_W), .LO_W(LO_W), .PWR_W(PWR_W)) u_ureg (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_hi   (clr_hi),
    .acc_add  (acc_add),
    .pwr_smp  (pwr_smp),
    .load_evt (load_evt),
    .load_val (isum),
    .user_q   (user_q),
    .ovf_evt  (usr_ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      rdy_q <= load_evt;
      ovf_q <= ovf_q || sum_ovf || usr_ovf;
    end
  end

  assign hi_word = user_q[ACC_W-1:LO_W];
  assign lo_word = user_q[LO_W-1:0];
  assign rdy     = rdy_q;
  assign ovf     = ovf_q;
endmodule

// File: rtl/egy_split_accum_chk.sv
module egy_split_accum_chk #(
  parameter int unsigned HI_W = 32,
  parameter int unsigned LO_W = 13
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_en,
  input logic            cfg_load,
  input logic [HI_W-1:0] hi_word,
  input logic [LO_W-1:0] lo_word,
  input logic            rdy,
  input logic            ovf,
  input logic            load_evt,
  input logic            clr_hi,
  input logic            acc_add
);
  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  // R4
  rdclr_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hi && !acc_add && !load_evt) |=> (hi_word == '0) && $stable(lo_word));

  // R3
  en_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !clr_hi) |=> $stable(hi_word) && $stable(lo_word) && !rdy);

  // R8
  rdy_after_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> rdy);

  // R8
  rdy_only_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> !rdy);

  // R8
  load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && !load_evt && !clr_hi) |=> $stable(hi_word) && $stable(lo_word));
endmodule

bind egy_split_accum egy_split_accum_chk #(.HI_W(HI_W), .LO_W(LO_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_en   (cfg_en),
  .cfg_load (cfg_load),
  .hi_word  (hi_word),
  .lo_word  (lo_word),
  .rdy      (rdy),
  .ovf      (ovf),
  .load_evt (load_evt),
  .clr_hi   (clr_hi),
  .acc_add  (acc_add)
);

// File: tb/egy_split_accum_tb.sv
module egy_split_accum_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_stb = 1'b0, hcyc_stb = 1'b0;
  logic [31:0] pwr_smp = '0;
  logic        cfg_en = 1'b0, cfg_load = 1'b0, cfg_tmr = 1'b0, cfg_rdclr = 1'b0;
  logic [15:0] cfg_intvl = '0;
  logic        rd_stb = 1'b0, rd_sel = 1'b0;
  logic [31:0] hi_word;
  logic [12:0] lo_word;
  logic        rdy, ovf;

  always #(CLK_PERIOD/2) clk = ~clk;

  egy_split_accum u_dut (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .hcyc_stb(hcyc_stb),
    .pwr_smp(pwr_smp), .cfg_en(cfg_en), .cfg_load(cfg_load), .cfg_tmr(cfg_tmr),
    .cfg_rdclr(cfg_rdclr), .cfg_intvl(cfg_intvl), .rd_stb(rd_stb), .rd_sel(rd_sel),
    .hi_word(hi_word), .lo_word(lo_word), .rdy(rdy), .ovf(ovf)
  );

  typedef struct {
    logic [31:0] hi;
    logic [12:0] lo;
    logic        rdy;
    logic        ovf;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_err = 0;
  bit   done  = 1'b0;

  // reference state, derived from the requirements
  longint m_user, m_isum, m_cnt;
  bit     m_rdy, m_ovf;

  localparam longint LIM = 64'sd1 <<< 44;

  function automatic longint wrap45(input longint v);
    longint r;
    r = (v + LIM) % (2*LIM);
    if (r < 0) r += 2*LIM;
    return r - LIM;
  endfunction

  function automatic bit out_of_range(input longint v);
    return (v >= LIM) || (v < -LIM);
  endfunction

  task automatic model_reset();
    m_user = 0; m_isum = 0; m_cnt = 0; m_rdy = 0; m_ovf = 0;
  endtask

  // drive one clock of stimulus (called at a falling edge) and queue the expectation
  task automatic step(input bit s, input bit h, input logic [31:0] p,
                      input bit rd, input bit sel, input string tag);
    longint sv, sum, base;
    bit clr, add, run, unit, evt;
    exp_t e;
    smp_stb = s; hcyc_stb = h; pwr_smp = p; rd_stb = rd; rd_sel = sel;
    sv   = longint'($signed(p));
    clr  = rd && sel && cfg_rdclr;
    add  = cfg_en && !cfg_load && s;
    run  = cfg_en && cfg_load;
    unit = cfg_tmr ? h : s;
    evt  = run && unit && (m_cnt >= longint'(cfg_intvl));
    base = clr ? (m_user & 64'h1FFF) : m_user;
    if (evt) begin
      m_user = m_isum;
    end else if (add) begin
      sum = base + sv;
      if (out_of_range(sum)) m_ovf = 1;
      m_user = wrap45(sum);
    end else begin
      m_user = base;
    end
    if (!run) m_isum = 0;
    else if (evt) m_isum = s ? sv : 0;
    else if (s) begin
      sum = m_isum + sv;
      if (out_of_range(sum)) m_ovf = 1;
      m_isum = wrap45(sum);
    end
    if (!run) m_cnt = 0;
    else if (unit) m_cnt = evt ? 0 : m_cnt + 1;
    m_rdy = evt;
    e.hi  = 32'(m_user >>> 13);
    e.lo  = 13'(m_user);
    e.rdy = m_rdy;
    e.ovf = m_ovf;
    e.tag = tag;
    @(posedge clk);
    exp_q.push_back(e);
    @(negedge clk);
    smp_stb = 0; hcyc_stb = 0; rd_stb = 0; rd_sel = 0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, '0, 0, 0, tag);
  endtask

  // monitor: compares after each rising edge, away from it
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_chk++;
        if (hi_word !== e.hi || lo_word !== e.lo || rdy !== e.rdy || ovf !== e.ovf) begin
          n_err++;
          $display("FAIL %s: got hi=%h lo=%h rdy=%b ovf=%b, expected hi=%h lo=%h rdy=%b ovf=%b",
                   e.tag, hi_word, lo_word, rdy, ovf, e.hi, e.lo, e.rdy, e.ovf);
        end
      end
    end
  end

  task automatic do_reset();
    rst_n = 0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: got running, expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    n_chk++;
    if (hi_word !== 0 || lo_word !== 0 || rdy !== 0 || ovf !== 0) begin
      n_err++;
      $display("FAIL R1: got hi=%h lo=%h rdy=%b ovf=%b, expected all zero",
               hi_word, lo_word, rdy, ovf);
    end

    // R2 free-running accumulation, mixed signs and gaps
    cfg_en = 1; cfg_load = 0; cfg_rdclr = 1;
    step(1, 0, 32'd5000, 0, 0, "R2");
    step(1, 0, 32'd9000, 0, 0, "R2");
    idle(1, "R2");
    step(1, 0, 32'hFFFF_0000, 0, 0, "R2");
    step(1, 0, 32'h7FFF_FFFF, 0, 0, "R2");
    step(1, 0, 32'h0012_3456, 0, 0, "R2");

    // R3 enable low: nothing moves
    cfg_en = 0;
    step(1, 0, 32'd777, 0, 0, "R3");
    step(1, 1, 32'hFFFF_FFF0, 0, 0, "R3");
    cfg_en = 1;

    // R4 reads without clear effect, then a clearing read
    step(0, 0, '0, 1, 0, "R4");
    cfg_rdclr = 0;
    step(0, 0, '0, 1, 1, "R4");
    cfg_rdclr = 1;
    step(0, 0, '0, 1, 1, "R4");
    step(1, 0, 32'h0100_0000, 0, 0, "R4");

    // R5 clear and sample on the same clock, incl. negative sample
    step(1, 0, 32'd12345, 1, 1, "R5");
    step(1, 0, 32'hFFFF_FF00, 1, 1, "R5");

    // R6 interval model counted in samples, length 4
    cfg_load = 1; cfg_tmr = 0; cfg_intvl = 16'd3;
    for (int i = 0; i < 14; i++)
      step(1, 0, 32'(1000 + i * 37), 0, 0, "R6");
    for (int i = 0; i < 6; i++)
      step(i % 2 == 0, 0, 32'hFFFF_F000, 0, 0, "R6");
    cfg_intvl = 16'd0;
    for (int i = 0; i < 4; i++) step(1, 0, 32'(i + 1), 0, 0, "R6");

    // R7 interval model counted in half cycles, length 2, coincident strobes
    cfg_tmr = 1; cfg_intvl = 16'd1;
    for (int i = 0; i < 24; i++)
      step(1, i % 5 == 4, 32'(300 * i + 11), 0, 0, "R7");
    // R8 words hold between ready events while samples keep coming
    for (int i = 0; i < 12; i++)
      step(1, i % 4 == 3, 32'd2048, 0, 0, "R8");

    // R9 ready event and clearing read on the same clock
    for (int i = 0; i < 8; i++)
      step(1, i % 3 == 2, 32'd9999, 1, 1, "R9");

    // R10 wrap and sticky overflow in the free-running model
    do_reset();
    cfg_en = 1; cfg_load = 0; cfg_tmr = 0;
    for (int i = 0; i < 8193; i++) step(1, 0, 32'h7FFF_FFFF, 0, 0, "R10");
    step(1, 0, 32'h8000_0000, 0, 0, "R10");
    idle(2, "R10");

    idle(1, "END");
    #(CLK_PERIOD);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule